// File: doc/BRIEF.md
# Dual-Period Watchdog Timer

This block supervises software activity by watching a single kick line for level changes in either direction. A free-running count of timebase ticks is compared against a deadline. If the deadline passes without a kick, the active-low watchdog output drops. Two deadlines exist. A long one gives the system room to boot after every reset. A short one applies once software has kicked for the first time, or once the long deadline has run out.

The block takes the reset state from a separate reset sequencer. That state is the system reset, an undervoltage flag, a manual reset level, and a one-cycle pulse marking the end of the reset timeout. While any reset source is active, the count is cleared and frozen. Counting restarts in long mode only on the end-of-timeout pulse. Undervoltage forces the watchdog output low. Manual reset and system reset force it high at once. In that way the output can be wired back to the manual reset input without latching the system in reset.

Top module: `dual_period_wdog`

## Requirements
- R1: A rising and a falling change of `kick_i` are both accepted as a kick. A kick takes effect on the third rising clock edge after the input changes. When the block is counting, that edge restarts the count and returns a low `wdo_no` to high.
- R2: After the clock edge that samples `rst_done_i` high, the block counts in long mode. With no kick, `wdo_no` falls on the edge that counts the `LONG_TICKS`-th tick, and not before. A static `kick_i` does not prevent this.
- R3: The first kick taking effect in long mode switches to short mode. `wdo_no` then falls on the `SHORT_TICKS`-th tick after the edge where the last kick took effect. Kicks spaced closer than `SHORT_TICKS` ticks keep `wdo_no` high.
- R4: When the long deadline expires, the mode changes to short. `wdo_no` stays low until a kick takes effect, and the next deadline is `SHORT_TICKS` ticks after that kick.
- R5: The count advances only on clock edges where `tick_i` is high. With `tick_i` low, no deadline ever passes.
- R6: While `sys_rst_i` is high and `uv_i` is low, `wdo_no` is high in the same cycle. Any reset source clears the count and holds the block idle. Once released, it stays idle with `wdo_no` high until `rst_done_i` is pulsed. After an active-low `rst_ni`, `wdo_no` is high and the block is idle.
- R7: While `uv_i` is high, `wdo_no` is low, whatever the other inputs are.
- R8: While `mr_i` is high and `uv_i` is low, `wdo_no` is high in the same cycle, and any pending timeout is discarded. After release and a `rst_done_i` pulse, the full long deadline applies again.
- R9: Kicks arriving while a reset source is active, or while the block is idle waiting for `rst_done_i`, have no effect. The deadline that follows `rst_done_i` is still the long one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick; one count per cycle it is high |
| kick_i | input | 1 | Asynchronous kick line; either level change is a kick |
| sys_rst_i | input | 1 | System reset output is asserted |
| uv_i | input | 1 | An undervoltage condition is present |
| mr_i | input | 1 | Manual reset is asserted |
| rst_done_i | input | 1 | One-cycle pulse at the end of the reset timeout |
| wdo_no | output | 1 | Watchdog output, active low |

## Verification
A mode register stuck in long mode shows as `wdo_no` falling `LONG_TICKS` ticks after a kick instead of `SHORT_TICKS`. A mode register left in short mode after a reset shows as a premature fall after `rst_done_i`. A count that is not cleared by a reset source shifts the next expiry earlier by the number of ticks left over, so checks sample `wdo_no` on the exact cycle before and after each deadline. Faults in the kick path surface within three cycles of a kick, as a low output that fails to release or a deadline that fails to move.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_LONG  = 2'd1,
    WD_SHORT = 2'd2
  } wd_mode_e;
endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= kick_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  // either direction counts
  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdog_mode_ctrl.sv
module wdog_mode_ctrl
  import wdog_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hold_i,
  input  logic     done_i,
  input  logic     kick_i,
  input  logic     expire_i,
  output wd_mode_e mode_o,
  output logic     bark_o
);
  wd_mode_e mode_q, mode_d;
  logic     bark_q, bark_d;

  always_comb begin
    mode_d = mode_q;
    bark_d = bark_q;
    if (hold_i) begin
      mode_d = WD_IDLE;
      bark_d = 1'b0;
    end else if (done_i) begin
      mode_d = WD_LONG;
      bark_d = 1'b0;
    end else if (mode_q != WD_IDLE && kick_i) begin
      mode_d = WD_SHORT;
      bark_d = 1'b0;
    end else if (expire_i) begin
      mode_d = WD_SHORT;
      bark_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= WD_IDLE;
      bark_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      bark_q <= bark_d;
    end
  end

  assign mode_o = mode_q;
  assign bark_o = bark_q;
endmodule

// File: rtl/wdog_tick_timer.sv
module wdog_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             arm_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = arm_i && !hold_i && !restart_i && tick_i &&
                    (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (hold_i || restart_i || expire_o) cnt_q <= '0;
    else if (arm_i && tick_i)               cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dual_period_wdog.sv
module dual_period_wdog
  import wdog_pkg::*;
#(
  parameter int LONG_TICKS  = 54,
  parameter int SHORT_TICKS = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic kick_i,
  input  logic sys_rst_i,
  input  logic uv_i,
  input  logic mr_i,
  input  logic rst_done_i,
  output logic wdo_no
);
  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  logic             hold, kick_edge, armed, restart, expire, bark;
  logic [CNT_W-1:0] limit, cnt_q;
  wd_mode_e         mode_q;

  assign hold = sys_rst_i | uv_i | mr_i;

  wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .edge_o (kick_edge)
  );

  wdog_mode_ctrl u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold),
    .done_i   (rst_done_i),
    .kick_i   (kick_edge),
    .expire_i (expire),
    .mode_o   (mode_q),
    .bark_o   (bark)
  );

  assign armed   = (mode_q != WD_IDLE);
  assign restart = rst_done_i | (armed & kick_edge);
  assign limit   = (mode_q == WD_SHORT) ? CNT_W'(SHORT_TICKS) : CNT_W'(LONG_TICKS);

  wdog_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold),
    .arm_i     (armed),
    .restart_i (restart),
    .tick_i    (tick_i),
    .limit_i   (limit),
    .cnt_o     (cnt_q),
    .expire_o  (expire)
  );

  // undervoltage dominates; reset sources release at once
  always_comb begin
    if (uv_i)                  wdo_no = 1'b0;
    else if (sys_rst_i | mr_i) wdo_no = 1'b1;
    else                       wdo_no = ~bark;
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int LONG_TICKS  = 54,
  parameter int SHORT_TICKS = 17,
  parameter int CNT_W       = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             sys_rst_i,
  input logic             uv_i,
  input logic             mr_i,
  input logic             rst_done_i,
  input logic             wdo_no,
  input wd_mode_e         mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             kick_edge
);
  logic hold;
  assign hold = sys_rst_i | uv_i | mr_i;

  assert_edge_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_edge && !hold && mode_q != WD_IDLE) |=> (cnt_q == '0 && wdo_no == 1'b1));

  assert_done_long_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_done_i && !hold) |=> (mode_q == WD_LONG && cnt_q == '0));

  assert_cnt_long_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < LONG_TICKS);

  assert_cnt_short_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WD_SHORT) |-> int'(cnt_q) < SHORT_TICKS);

  assert_no_tick_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !hold && !kick_edge && !rst_done_i) |=> $stable(cnt_q));

  assert_hold_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (cnt_q == '0 && mode_q == WD_IDLE));

  assert_uv_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> !wdo_no);

  assert_mr_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_i && !uv_i) |-> wdo_no);

  assert_idle_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WD_IDLE && !rst_done_i) |=> (mode_q == WD_IDLE && cnt_q == '0));
endmodule

bind dual_period_wdog wdog_checker #(
  .LONG_TICKS  (LONG_TICKS),
  .SHORT_TICKS (SHORT_TICKS),
  .CNT_W       (CNT_W)
) i_wdog_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .sys_rst_i  (sys_rst_i),
  .uv_i       (uv_i),
  .mr_i       (mr_i),
  .rst_done_i (rst_done_i),
  .wdo_no     (wdo_no),
  .mode_q     (mode_q),
  .cnt_q      (cnt_q),
  .kick_edge  (kick_edge)
);

// File: tb/test_dual_period_wdog.sv
module test_dual_period_wdog;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int LONG  = 20;
  localparam int SHORT = 6;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b1, kick = 1'b0, srst = 1'b0, uv = 1'b0, mr = 1'b0, done = 1'b0;
  logic wdo_n;
  int   checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  dual_period_wdog #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT), .SYNC_STAGES(2)) i_dual_period_wdog (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .kick_i(kick), .sys_rst_i(srst),
    .uv_i(uv), .mr_i(mr), .rst_done_i(done), .wdo_no(wdo_n)
  );

  // {uv, mr, srst, expected wdo_no} with a pending timeout
  typedef logic [3:0] vec_t;
  localparam vec_t VECS [8] = '{
    4'b0000, 4'b1000, 4'b0101, 4'b0011,
    4'b1100, 4'b1010, 4'b0111, 4'b1110
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: wdo_no=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk) done = 1'b1;
    @(negedge clk) done = 1'b0;
  endtask

  task automatic toggle_kick();
    @(negedge clk) kick = ~kick;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_expiry(input int n, input string req);
    repeat (n - 1) @(negedge clk);
    check(wdo_n, 1'b1, req);
    @(negedge clk);
    check(wdo_n, 1'b0, req);
  endtask

  task automatic sys_reset_cycle();
    @(negedge clk) srst = 1'b1;
    repeat (2) @(negedge clk);
    srst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #0.5 check(wdo_n, 1'b1, "R6 reset state");
    repeat (30) @(negedge clk);
    check(wdo_n, 1'b1, "R9 idle before done");

    // long deadline with static kick
    pulse_done();
    expect_expiry(LONG, "R2 long expiry");

    // override table, probed between clock edges
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {uv, mr, srst} = VECS[i][3:1];
      #0.5 check(wdo_n, VECS[i][0], "R7/R8/R6 override table");
      uv = 1'b0; mr = 1'b0; srst = 1'b0;
    end
    #0.5 check(wdo_n, 1'b0, "R7 table left state intact");

    // stays low in short mode until kicked; rising kick releases
    repeat (SHORT + 2) @(negedge clk);
    check(wdo_n, 1'b0, "R4 stays low");
    @(negedge clk) kick = 1'b1;
    repeat (2) @(negedge clk);
    check(wdo_n, 1'b0, "R1 kick not yet effective");
    @(negedge clk);
    check(wdo_n, 1'b1, "R1 rising kick releases");
    expect_expiry(SHORT, "R4 short after long expiry");

    // falling kick releases
    toggle_kick();
    check(wdo_n, 1'b1, "R1 falling kick releases");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk) kick = ~kick;
      repeat (SHORT - 1) @(negedge clk);
      check(wdo_n, 1'b1, "R3 regular kicks keep alive");
    end
    toggle_kick();
    expect_expiry(SHORT, "R3 short deadline after kick");

    // first kick in long mode switches to short
    sys_reset_cycle();
    #0.5 check(wdo_n, 1'b1, "R6 released after reset");
    pulse_done();
    repeat (2) @(negedge clk);
    toggle_kick();
    expect_expiry(SHORT, "R3 long to short switch");

    // tick gating
    sys_reset_cycle();
    tick = 1'b0;
    pulse_done();
    repeat (3 * LONG) @(negedge clk);
    check(wdo_n, 1'b1, "R5 no tick no expiry");
    for (int i = 0; i < LONG - 1; i++) begin
      tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    check(wdo_n, 1'b1, "R5 one tick short of deadline");
    tick = 1'b1;
    @(negedge clk);
    check(wdo_n, 1'b0, "R5 expiry on last tick");

    // kicks during hold and idle are ignored
    @(negedge clk) srst = 1'b1;
    toggle_kick();
    srst = 1'b0;
    toggle_kick();
    repeat (2) @(negedge clk);
    check(wdo_n, 1'b1, "R9 idle after hold");
    pulse_done();
    expect_expiry(LONG, "R9 kicks in idle ignored");

    // watchdog output looped to manual reset
    @(negedge clk) begin mr = 1'b1; srst = 1'b1; end
    #0.5 check(wdo_n, 1'b1, "R8 manual reset releases at once");
    @(negedge clk) mr = 1'b0;
    #0.5 check(wdo_n, 1'b1, "R8 timeout discarded");
    repeat (3) @(negedge clk);
    srst = 1'b0;
    repeat (5) @(negedge clk);
    check(wdo_n, 1'b1, "R8 idle until done");
    pulse_done();
    expect_expiry(LONG, "R8 long deadline after manual reset");

    // undervoltage
    sys_reset_cycle();
    pulse_done();
    repeat (3) @(negedge clk);
    uv = 1'b1;
    #0.5 check(wdo_n, 1'b0, "R7 undervoltage forces low");
    @(negedge clk) srst = 1'b1;
    #0.5 check(wdo_n, 1'b0, "R7 undervoltage dominates reset");
    @(negedge clk) uv = 1'b0;
    #0.5 check(wdo_n, 1'b1, "R6 high under reset after undervoltage");
    srst = 1'b0;
    repeat (LONG + 5) @(negedge clk);
    check(wdo_n, 1'b1, "R6 frozen without done");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule